// File: doc/BRIEF.md
# Auto-Increment Word-Program Sequencer

This block writes a run of bytes into a serial flash device that offers an auto-address-increment word-program command. The host gives a start pulse with a byte address and a byte count, then supplies the data as a valid/ready byte stream. The block breaks the run into SPI frames and hands them, one byte at a time, to an SPI master. It also reads the device status between frames.

Unaligned edges are handled with single-byte program frames. If the run starts on an odd address, one byte goes out first. If one byte is left after the aligned middle, it goes out last. The aligned middle is sent as two-byte words in one auto-increment session. The first word frame carries the opcode and the address. Each later word frame carries only the opcode and its two data bytes. The session is closed with a write-disable frame.

After each program frame and after the session-closing write disable, the block polls the status register until the busy bit clears. If the device stays busy for too many consecutive polls, the block gives up and reports an error.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for start.
- `ST_WREN`: sends the opening write enable.
- `ST_LEAD`: sends the odd leading single byte.
- `ST_WORD`: sends one word frame, with or without the address.
- `ST_WRDI`: closes the session with write disable.
- `ST_TAIL_WREN`, `ST_TAIL_BYTE`, `ST_TAIL_WRDI`: handle the trailing single byte.
- `ST_POLL`: sends status frames and returns to a remembered state.
- `ST_DONE`: the one-cycle completion state.

The transitions are:
- `ST_IDLE` goes to `ST_DONE` for an empty run, otherwise to `ST_WREN`.
- `ST_WREN` goes to `ST_LEAD` on an odd address. Otherwise it goes to the middle step, which is `ST_WORD` if two or more bytes remain and `ST_WRDI` if not.
- `ST_LEAD`, `ST_WORD`, `ST_WRDI` and `ST_TAIL_BYTE` go to `ST_POLL`.
- On an idle status, `ST_POLL` goes from a lead or word frame to the middle step. From `ST_WRDI` it goes to `ST_TAIL_WREN` if a byte remains, or to `ST_DONE` if none does. From `ST_TAIL_BYTE` it goes to `ST_TAIL_WRDI`.
- On a busy status, `ST_POLL` repeats itself, or goes to `ST_DONE` with the error flag once the poll limit is reached.
- `ST_TAIL_WREN` goes to `ST_TAIL_BYTE`.
- `ST_TAIL_WRDI` goes to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `aai_word_prog_seq`

## Requirements
- R1: A start with a byte count of zero pulses `done` in the cycle after start. `acc_count` is then 0, `err` is low and no SPI byte is requested.
- R2: Every non-empty operation opens with exactly one frame of the single byte 0x06 (write enable), before any program frame.
- R3: When the start address is odd (address bit 0 = 1), the first program frame is 0x02, then the address in ADDR_BYTES bytes with the most significant byte first, then one data byte.
- R4: The first word frame of the session is 0xAD, then the current address with the most significant byte first, then two data bytes in stream order.
- R5: Every later word frame of the same session is 0xAD followed by only its two data bytes, with no address.
- R6: After every program frame and after the session-closing write disable, the block sends status frames of the two bytes 0x05 and 0x00. It keeps sending them while bit 0 of the byte received with the 0x00 is 1. It continues as soon as that bit reads 0.
- R7: After the aligned middle, the block always sends the single-byte frame 0x04 (write disable), even when no word was sent.
- R8: If one byte remains after the middle, the block sends 0x06, then a 0x02 frame with address and one data byte, then status polling, then 0x04. It then completes with `err` low.
- R9: If POLL_LIMIT consecutive status reads show busy, the block pulses `done` with `err` high. It requests no further SPI byte.
- R10: `acc_count` counts the data bytes taken from the stream in the current operation. On a completion without error it equals the start byte count.
- R11: The device address advances by 1 for each single byte and by 2 for each word. The trailing single byte therefore carries address start + count - 1.
- R12: Outside an operation, `m_valid` and `in_ready` stay low. `done` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts an operation when the block is idle |
| start_addr | input | 8*ADDR_BYTES | First device byte address |
| start_len | input | LEN_W | Number of data bytes to write |
| in_valid | input | 1 | Data stream byte is valid |
| in_data | input | 8 | Data stream byte |
| in_ready | output | 1 | Data stream byte is taken this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status poll timed out; valid with done |
| acc_count | output | LEN_W | Data bytes taken in the current operation |
| m_valid | output | 1 | SPI byte request to the master |
| m_byte | output | 8 | Byte to shift out |
| m_last | output | 1 | Chip select is released after this byte |
| m_ready | input | 1 | Master takes the requested byte |
| m_done | input | 1 | Master finished shifting the byte |
| m_rx | input | 8 | Byte shifted in during that transfer |

## Verification
The hardest situation to reach is the poll timeout. It needs the device to report busy for POLL_LIMIT reads in a row in the middle of a session. The bench handles this with its SPI master model, which plays the device: it answers each status read with a programmable number of busy replies before it reports idle. Setting that number above the poll limit, with a small limit parameter on the instance, forces the abort right after the first word frame. The odd-start, odd-end and count-one cases are reached by picking address parity and length so that the lead, middle and tail phases appear alone and in every combination.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;

    localparam logic [7:0] OP_WR_EN     = 8'h06;
    localparam logic [7:0] OP_WR_DIS    = 8'h04;
    localparam logic [7:0] OP_RD_STAT   = 8'h05;
    localparam logic [7:0] OP_BYTE_PROG = 8'h02;
    localparam logic [7:0] OP_WORD_AAI  = 8'hAD;

    typedef enum logic [2:0] {
        FK_WREN,
        FK_WRDI,
        FK_STAT,
        FK_BYTE,
        FK_WORD_HEAD,
        FK_WORD_NEXT
    } frame_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_LEAD,
        ST_WORD,
        ST_WRDI,
        ST_TAIL_WREN,
        ST_TAIL_BYTE,
        ST_TAIL_WRDI,
        ST_POLL,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/aai_frame_mux.sv
module aai_frame_mux
    import aai_seq_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int IDX_W      = 3
) (
    input  frame_kind_t               kind,
    input  logic [IDX_W-1:0]          idx,
    input  logic [8*ADDR_BYTES-1:0]   addr,
    input  logic [7:0]                data,
    output logic [7:0]                tx_byte,
    output logic                      tx_last,
    output logic                      tx_is_data
);
    localparam int HEAD_LAST = ADDR_BYTES + 2;

    // Selects one address byte, most significant first, for idx 1..ADDR_BYTES.
    function automatic logic [7:0] addr_byte(input logic [8*ADDR_BYTES-1:0] a,
                                             input int pos);
        return 8'(a >> (8 * (ADDR_BYTES - pos)));
    endfunction

    always_comb begin
        tx_byte    = 8'h00;
        tx_last    = 1'b0;
        tx_is_data = 1'b0;
        unique case (kind)
            FK_WREN: begin
                tx_byte = OP_WR_EN;
                tx_last = 1'b1;
            end
            FK_WRDI: begin
                tx_byte = OP_WR_DIS;
                tx_last = 1'b1;
            end
            FK_STAT: begin
                if (idx == '0) begin
                    tx_byte = OP_RD_STAT;
                end else begin
                    tx_byte = 8'h00;
                    tx_last = 1'b1;
                end
            end
            FK_BYTE: begin
                if (idx == '0) begin
                    tx_byte = OP_BYTE_PROG;
                end else if (int'(idx) <= ADDR_BYTES) begin
                    tx_byte = addr_byte(addr, int'(idx));
                end else begin
                    tx_byte    = data;
                    tx_is_data = 1'b1;
                    tx_last    = 1'b1;
                end
            end
            FK_WORD_HEAD: begin
                if (idx == '0) begin
                    tx_byte = OP_WORD_AAI;
                end else if (int'(idx) <= ADDR_BYTES) begin
                    tx_byte = addr_byte(addr, int'(idx));
                end else begin
                    tx_byte    = data;
                    tx_is_data = 1'b1;
                    tx_last    = (int'(idx) == HEAD_LAST);
                end
            end
            FK_WORD_NEXT: begin
                if (idx == '0) begin
                    tx_byte = OP_WORD_AAI;
                end else begin
                    tx_byte    = data;
                    tx_is_data = 1'b1;
                    tx_last    = (int'(idx) == 2);
                end
            end
            default: begin
                tx_byte = 8'h00;
            end
        endcase
    end

endmodule

// File: rtl/aai_addr_track.sv
module aai_addr_track #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  remaining,
    output logic [LEN_W-1:0]  accepted
);
    // One step per data byte: a word moves the address by two.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
            accepted  <= '0;
        end else if (load) begin
            cur_addr  <= load_addr;
            remaining <= load_len;
            accepted  <= '0;
        end else if (step) begin
            cur_addr  <= cur_addr + 1'b1;
            remaining <= remaining - 1'b1;
            accepted  <= accepted + 1'b1;
        end
    end

endmodule

// File: rtl/aai_poll_guard.sv
module aai_poll_guard #(
    parameter int POLL_LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic busy_read,
    output logic expired
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    logic [CNT_W-1:0] busy_cnt;

    assign expired = busy_read && (busy_cnt == CNT_W'(POLL_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (clear) begin
            busy_cnt <= '0;
        end else if (busy_read) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/aai_word_prog_seq.sv
module aai_word_prog_seq
    import aai_seq_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int LEN_W      = 16,
    parameter int POLL_LIMIT = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [8*ADDR_BYTES-1:0] start_addr,
    input  logic [LEN_W-1:0]        start_len,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    in_ready,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [LEN_W-1:0]        acc_count,
    output logic                    m_valid,
    output logic [7:0]              m_byte,
    output logic                    m_last,
    input  logic                    m_ready,
    input  logic                    m_done,
    input  logic [7:0]              m_rx
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int IDX_W  = $clog2(ADDR_BYTES + 3);

    seq_state_t        state_q, state_d, resume_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wait_q;
    logic              first_word_q;
    logic              err_q;

    frame_kind_t       kind;
    logic              in_frame;
    logic [7:0]        tx_byte;
    logic              tx_last;
    logic              tx_is_data;
    logic              fire;
    logic              byte_done;
    logic              frame_end;
    logic              start_take;
    logic              stat_busy;
    logic              poll_enter;
    logic              poll_busy_read;
    logic              poll_expired;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remaining;
    logic [LEN_W-1:0]  accepted;
    seq_state_t        middle_st;
    logic              unused_rx;

    assign unused_rx = ^m_rx[7:1];
    assign stat_busy = m_rx[0];

    aai_frame_mux #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W)
    ) u_frame_mux (
        .kind       (kind),
        .idx        (idx_q),
        .addr       (cur_addr),
        .data       (in_data),
        .tx_byte    (tx_byte),
        .tx_last    (tx_last),
        .tx_is_data (tx_is_data)
    );

    aai_addr_track #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_addr_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_take),
        .load_addr (start_addr),
        .load_len  (start_len),
        .step      (fire && tx_is_data),
        .cur_addr  (cur_addr),
        .remaining (remaining),
        .accepted  (accepted)
    );

    aai_poll_guard #(
        .POLL_LIMIT (POLL_LIMIT)
    ) u_poll_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (poll_enter),
        .busy_read (poll_busy_read),
        .expired   (poll_expired)
    );

    // Byte-level handshake terms shared by the two processes below.
    assign start_take     = (state_q == ST_IDLE) && start;
    assign fire           = m_valid && m_ready;
    assign byte_done      = wait_q && m_done;
    assign frame_end      = byte_done && tx_last;
    assign poll_enter     = (state_q != ST_POLL) && (state_d == ST_POLL);
    assign poll_busy_read = (state_q == ST_POLL) && frame_end && stat_busy;
    assign middle_st      = (remaining >= LEN_W'(2)) ? ST_WORD : ST_WRDI;

    // State register and per-frame bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            resume_q     <= ST_IDLE;
            idx_q        <= '0;
            wait_q       <= 1'b0;
            first_word_q <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                wait_q <= 1'b1;
            end else if (byte_done) begin
                wait_q <= 1'b0;
            end
            if (start_take || frame_end) begin
                idx_q <= '0;
            end else if (byte_done) begin
                idx_q <= idx_q + 1'b1;
            end
            if (poll_enter) begin
                resume_q <= state_q;
            end
            if (start_take) begin
                first_word_q <= 1'b1;
            end else if ((state_q == ST_WORD) && frame_end) begin
                first_word_q <= 1'b0;
            end
            if (start_take) begin
                err_q <= 1'b0;
            end else if (poll_expired) begin
                err_q <= 1'b1;
            end
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (start_len == '0) ? ST_DONE : ST_WREN;
                end
            end
            ST_WREN: begin
                if (frame_end) begin
                    state_d = cur_addr[0] ? ST_LEAD : middle_st;
                end
            end
            ST_LEAD, ST_WORD, ST_WRDI, ST_TAIL_BYTE: begin
                if (frame_end) begin
                    state_d = ST_POLL;
                end
            end
            ST_TAIL_WREN: begin
                if (frame_end) begin
                    state_d = ST_TAIL_BYTE;
                end
            end
            ST_TAIL_WRDI: begin
                if (frame_end) begin
                    state_d = ST_DONE;
                end
            end
            ST_POLL: begin
                if (frame_end) begin
                    if (stat_busy) begin
                        state_d = poll_expired ? ST_DONE : ST_POLL;
                    end else begin
                        unique case (resume_q)
                            ST_LEAD, ST_WORD: state_d = middle_st;
                            ST_WRDI:          state_d = (remaining != '0) ? ST_TAIL_WREN : ST_DONE;
                            ST_TAIL_BYTE:     state_d = ST_TAIL_WRDI;
                            default:          state_d = ST_DONE;
                        endcase
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs and frame selection from the current state.
    always_comb begin
        kind     = FK_WREN;
        in_frame = 1'b1;
        unique case (state_q)
            ST_WREN, ST_TAIL_WREN: kind = FK_WREN;
            ST_WRDI, ST_TAIL_WRDI: kind = FK_WRDI;
            ST_LEAD, ST_TAIL_BYTE: kind = FK_BYTE;
            ST_WORD:               kind = first_word_q ? FK_WORD_HEAD : FK_WORD_NEXT;
            ST_POLL:               kind = FK_STAT;
            default:               in_frame = 1'b0;
        endcase
        m_valid   = in_frame && !wait_q && (!tx_is_data || in_valid);
        m_byte    = tx_byte;
        m_last    = tx_last;
        in_ready  = in_frame && !wait_q && tx_is_data && m_ready;
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        err       = (state_q == ST_DONE) && err_q;
        acc_count = accepted;
    end

endmodule

// File: rtl/aai_word_prog_seq_chk.sv
module aai_word_prog_seq_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] start_len,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [LEN_W-1:0] acc_count,
    input logic             m_valid,
    input logic             in_ready
);
    logic [LEN_W-1:0] len_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_cap <= '0;
        end else if (start && !busy) begin
            len_cap <= start_len;
        end
    end

    a_r1_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_len == '0) |=> (done && acc_count == '0));

    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!m_valid && !in_ready));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (acc_count <= len_cap));

    a_r10_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (acc_count == len_cap));

    a_r9_stop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !m_valid);

endmodule

bind aai_word_prog_seq aai_word_prog_seq_chk #(
    .LEN_W (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_len (start_len),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .acc_count (acc_count),
    .m_valid   (m_valid),
    .in_ready  (in_ready)
);

// File: tb/aai_word_prog_seq_bench.sv
module aai_word_prog_seq_bench;
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int LEN_W      = 16;
    localparam int POLL_LIMIT = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  start_len = '0;
    logic              in_valid;
    logic [7:0]        in_data;
    logic              in_ready;
    logic              busy, done, err;
    logic [LEN_W-1:0]  acc_count;
    logic              m_valid, m_last;
    logic [7:0]        m_byte;
    logic              m_ready = 1'b0;
    logic              m_done = 1'b0;
    logic [7:0]        m_rx = 8'h00;

    always #5 clk = ~clk;

    aai_word_prog_seq #(
        .ADDR_BYTES (ADDR_BYTES),
        .LEN_W      (LEN_W),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_aai_word_prog_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .start_addr (start_addr),
        .start_len (start_len), .in_valid (in_valid), .in_data (in_data),
        .in_ready (in_ready), .busy (busy), .done (done), .err (err),
        .acc_count (acc_count), .m_valid (m_valid), .m_byte (m_byte),
        .m_last (m_last), .m_ready (m_ready), .m_done (m_done), .m_rx (m_rx)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    int         busy_cfg = 0;
    logic [7:0] data_base = 8'h00;
    int         data_k = 0;
    bit         finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Host data source: always valid, byte k of an operation is data_base + k.
    initial begin
        in_valid = 1'b0;
        in_data  = 8'h00;
        forever begin
            @(posedge clk);
            if (in_valid && in_ready) data_k++;
            in_data  <= data_base + 8'(data_k);
            in_valid <= 1'b1;
        end
    end

    // SPI master and device model; the monitor half pops the scoreboard.
    initial begin
        int         phase = 0;
        int         cnt = 0;
        int         pos = 0;
        int         busy_left = 0;
        logic [7:0] first_b = 8'h00;
        logic [7:0] rx_hold = 8'hFF;
        logic [8:0] e;
        string      t;
        forever begin
            @(negedge clk);
            m_done = 1'b0;
            if (phase == 0) begin
                if (m_ready) begin
                    m_ready = 1'b0;
                    phase = 1;
                    cnt = 1;
                end else if (m_valid) begin
                    m_ready = 1'b1;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", "unexpected SPI byte", int'({m_last, m_byte}), 0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({m_last, m_byte} == e, t, "frame byte {last,byte}",
                              int'({m_last, m_byte}), int'(e));
                    end
                    if (pos == 0) begin
                        first_b = m_byte;
                        if (m_byte != 8'h05) busy_left = busy_cfg;
                    end
                    if (pos == 1 && first_b == 8'h05) begin
                        rx_hold = (busy_left > 0) ? 8'h03 : 8'h02;
                        if (busy_left > 0) busy_left--;
                    end else begin
                        rx_hold = 8'hFF;
                    end
                    pos = m_last ? 0 : pos + 1;
                end
            end else begin
                if (cnt == 0) begin
                    m_done = 1'b1;
                    m_rx   = rx_hold;
                    phase  = 0;
                end else begin
                    cnt--;
                end
            end
        end
    end

    task automatic push(input logic [7:0] b, input bit last, input string tag);
        exp_q.push_back({last, b});
        tag_q.push_back(tag);
    endtask

    task automatic push_addr(input logic [ADDR_W-1:0] a, input string tag);
        for (int i = ADDR_BYTES - 1; i >= 0; i--) push(8'(a >> (8 * i)), 1'b0, tag);
    endtask

    task automatic push_polls(input int b, input string tag);
        for (int i = 0; i <= b; i++) begin
            push(8'h05, 1'b0, tag);
            push(8'h00, 1'b1, tag);
        end
    endtask

    // Expected frames from the requirements for a normal (non-timeout) run.
    task automatic plan_op(input logic [ADDR_W-1:0] addr, input int len, input int b);
        logic [ADDR_W-1:0] a = addr;
        int r = len;
        int k = 0;
        bit first = 1'b1;
        if (len == 0) return;
        push(8'h06, 1'b1, "R2");
        if (a[0]) begin
            push(8'h02, 1'b0, "R3");
            push_addr(a, "R3");
            push(data_base + 8'(k), 1'b1, "R3");
            push_polls(b, "R6");
            a = a + 1; r--; k++;
        end
        while (r >= 2) begin
            push(8'hAD, 1'b0, first ? "R4" : "R5");
            if (first) push_addr(a, "R4");
            push(data_base + 8'(k), 1'b0, first ? "R4" : "R5");
            push(data_base + 8'(k + 1), 1'b1, first ? "R4" : "R5");
            push_polls(b, "R6");
            a = a + 2; r -= 2; k += 2; first = 1'b0;
        end
        push(8'h04, 1'b1, "R7");
        push_polls(b, "R6");
        if (r == 1) begin
            push(8'h06, 1'b1, "R8");
            push(8'h02, 1'b0, "R8");
            push_addr(a, "R11");
            push(data_base + 8'(k), 1'b1, "R8");
            push_polls(b, "R6");
            push(8'h04, 1'b1, "R8");
        end
    endtask

    task automatic run_op(input logic [ADDR_W-1:0] addr, input int len, input int b,
                          input bit timeout_case, input logic [7:0] base);
        int w = 0;
        int exp_acc = timeout_case ? 2 : len;
        busy_cfg  = b;
        data_base = base;
        data_k    = 0;
        if (timeout_case) begin
            push(8'h06, 1'b1, "R2");
            push(8'hAD, 1'b0, "R4");
            push_addr(addr, "R4");
            push(base, 1'b0, "R4");
            push(base + 8'd1, 1'b1, "R4");
            for (int i = 0; i < POLL_LIMIT; i++) begin
                push(8'h05, 1'b0, "R9");
                push(8'h00, 1'b1, "R9");
            end
        end else begin
            plan_op(addr, len, b);
        end
        @(negedge clk);
        start      = 1'b1;
        start_addr = addr;
        start_len  = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        if (len == 0) begin
            check(done == 1'b1, "R1", "done one cycle after start", int'(done), 1);
        end
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        check(done == 1'b1, "R10", "operation completes", int'(done), 1);
        check(err == timeout_case, timeout_case ? "R9" : "R8", "err at done", int'(err),
              int'(timeout_case));
        check(acc_count == LEN_W'(exp_acc), "R10", "accepted count", int'(acc_count), exp_acc);
        check(exp_q.size() == 0, "R6", "expected frames left", exp_q.size(), 0);
        @(negedge clk);
        check(done == 1'b0, "R12", "done is a single pulse", int'(done), 0);
        repeat (12) @(negedge clk);
        check(m_valid == 1'b0 && in_ready == 1'b0, "R12", "quiet after completion",
              int'({m_valid, in_ready}), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, err, m_valid, in_ready} == 5'b0, "R12", "reset outputs",
              int'({busy, done, err, m_valid, in_ready}), 0);
        check(acc_count == '0, "R10", "reset count", int'(acc_count), 0);

        // R1 empty run
        run_op(24'h000400, 0, 0, 1'b0, 8'h10);
        // R4 R5 aligned words only, no polling delay
        run_op(24'h001000, 6, 0, 1'b0, 8'h20);
        // R3 odd start, two words, no tail, busy replies
        run_op(24'h0200A3, 5, 2, 1'b0, 8'h30);
        // R8 R11 odd start with a trailing byte
        run_op(24'h0300F1, 6, 1, 1'b0, 8'h40);
        // R7 R8 single byte at even address: close without words, then tail
        run_op(24'h004000, 1, 0, 1'b0, 8'h50);
        // R3 R7 single byte at odd address
        run_op(24'h004001, 1, 1, 1'b0, 8'h60);
        // R11 one word plus tail
        run_op(24'h00FFFE, 3, 0, 1'b0, 8'h70);
        // R3 R8 odd start, length 2: lead and tail, no word
        run_op(24'h123457, 2, 0, 1'b0, 8'h80);
        // R9 timeout after first word
        run_op(24'h002000, 4, 1000, 1'b1, 8'h90);
        // R10 normal run after an abort
        run_op(24'h002001, 8, 1, 1'b0, 8'hA0);

        finish_run();
    end

endmodule